// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block arbitrates a set of numbered interrupt levels for a processor core. Each level can be raised by a software strobe. A raised level is latched in a pending vector, and an enable mask decides which latched levels may be serviced. A lower level number means a higher priority. When a serviceable request may preempt the work in progress, the block emits a one-cycle take strobe. With the strobe it gives the level number, the handler address from a per-level vector table, and the return address the core must save. That return address is the current program counter with bit 0 marking a self-nested entry.

The core ends a handler with a return strobe and bit 0 of the return address it resumes at. If that bit is clear, the highest-priority in-service level retires. If it is set, the level stays in service, whether or not self-nesting is enabled. Self-nesting is switched by one configuration input. When it is on, re-raising the level in service is taken at once. When it is off, the re-raise waits in the pending vector until the handler returns.

A small controller sequences the work through three states:
- READY: the state where arbitration may take a request.
- ENTER: the cycle in which the take strobe is high.
- LEAVE: a one-cycle settle after a return.

The transitions are:
- READY→ENTER when a take is decided.
- Any state→LEAVE on a return strobe.
- ENTER→READY when there is no return.
- LEAVE→READY when there is no return.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the pending and in-service vectors are all zero and the take strobe is low.
- R2: A raise strobe on level n sets pending bit n. A level whose enable bit (bit n of the mask) is clear stays pending and is never taken.
- R3: When several enabled levels are pending at once, the lowest-numbered one is taken first. Disabled levels are skipped.
- R4: On a take, the strobe is high for exactly one cycle. On the same edge, pending bit n clears and in-service bit n sets. The take level equals n and the take vector equals the table entry written for level n.
- R5: A pending level is taken only if its number is strictly lower than the lowest-numbered in-service level. Self-nested re-entry (R7) is the only exception.
- R6: With self-nesting disabled, re-raising the level in service only sets its pending bit. It is taken after a return that retires the level. Any entry that is not self-nested saves a return address with bit 0 = 0.
- R7: With self-nesting enabled, re-raising the level in service is taken without a return. The saved return address then has bit 0 = 1, and the in-service vector is unchanged.
- R8: On a return with tag bit 1, the in-service vector is unchanged, even with self-nesting disabled. On a return with tag bit 0, only the lowest-numbered in-service bit clears.
- R9: A return blocks any take on its own clock edge and on the following edge. A raise given in the same cycle as a return is still latched, and it is taken afterwards.
- R10: The saved return address equals the current program counter input with bit 0 replaced by the self-nest flag. A vector write to level n replaces the address reported for level n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raise_i | input | NLVL | Software raise strobes, one per level |
| enable_i | input | NLVL | Enable mask, bit n for level n |
| nest_en_i | input | 1 | Self-nesting enable |
| vec_we_i | input | 1 | Vector table write strobe |
| vec_sel_i | input | LW | Level whose vector is written |
| vec_data_i | input | AW | Handler address to write |
| cur_pc_i | input | AW | Program counter to save on entry |
| ret_i | input | 1 | Return-from-interrupt strobe |
| ret_tag_i | input | 1 | Bit 0 of the address being returned to |
| pend_o | output | NLVL | Pending vector |
| inserv_o | output | NLVL | In-service vector |
| take_o | output | 1 | Take-interrupt strobe, one cycle |
| take_level_o | output | LW | Level being taken |
| take_vector_o | output | AW | Handler address of that level |
| saved_ret_o | output | AW | Return address to save, bit 0 = self-nest flag |

## Verification
Two functions can fall in the same cycle: a return and a raise of the level being retired. The bench drives the return strobe and the raise strobe in the same cycle. It judges the result by three observations: no take for two edges, the in-service bit already cleared, and the pending bit already set. The level must then be taken on the third edge. A second overlap is an arbitration decision made while several levels pend and a lower-priority one is disabled. This is judged by the order and level of the take strobes that follow.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_ENTER = 2'd1,
        ST_LEAVE = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/irq_lowest_set.sv
module irq_lowest_set #(
    parameter int N = 16,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    output logic         found_o,
    output logic [W-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
    parameter int NLVL = 16,
    parameter int AW   = 32,
    parameter int LW   = $clog2(NLVL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [LW-1:0] wsel_i,
    input  logic [AW-1:0] wdata_i,
    input  logic [LW-1:0] rsel_i,
    output logic [AW-1:0] rdata_o
);

    logic [AW-1:0] entry_q [NLVL];

    for (genvar g = 0; g < NLVL; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (we_i && (wsel_i == LW'(g))) begin
                entry_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = entry_q[rsel_i];

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_pkg::*;
#(
    parameter int NLVL = 16,
    parameter int AW   = 32,
    parameter int LW   = $clog2(NLVL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] raise_i,
    input  logic [NLVL-1:0] enable_i,
    input  logic            nest_en_i,
    input  logic            vec_we_i,
    input  logic [LW-1:0]   vec_sel_i,
    input  logic [AW-1:0]   vec_data_i,
    input  logic [AW-1:0]   cur_pc_i,
    input  logic            ret_i,
    input  logic            ret_tag_i,
    output logic [NLVL-1:0] pend_o,
    output logic [NLVL-1:0] inserv_o,
    output logic            take_o,
    output logic [LW-1:0]   take_level_o,
    output logic [AW-1:0]   take_vector_o,
    output logic [AW-1:0]   saved_ret_o
);

    ctl_state_e state_q, state_d;

    logic [NLVL-1:0] pend_q;
    logic [NLVL-1:0] inserv_q;
    logic [NLVL-1:0] cand;
    logic            cand_found;
    logic [LW-1:0]   cand_idx;
    logic            act_found;
    logic [LW-1:0]   act_idx;
    logic            may_preempt;
    logic            self_nest;
    logic            take_now;
    logic [NLVL-1:0] take_mask;
    logic [NLVL-1:0] retire_mask;
    logic [AW-1:0]   vec_rd;

    assign cand = pend_q & enable_i;

    irq_lowest_set #(.N(NLVL), .W(LW)) u_cand_enc (
        .vec_i   (cand),
        .found_o (cand_found),
        .idx_o   (cand_idx)
    );

    irq_lowest_set #(.N(NLVL), .W(LW)) u_act_enc (
        .vec_i   (inserv_q),
        .found_o (act_found),
        .idx_o   (act_idx)
    );

    irq_vec_table #(.NLVL(NLVL), .AW(AW), .LW(LW)) u_vtab (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (vec_we_i),
        .wsel_i  (vec_sel_i),
        .wdata_i (vec_data_i),
        .rsel_i  (cand_idx),
        .rdata_o (vec_rd)
    );

    // Arbitration: strictly higher priority, or re-entry of the active level
    // when self-nesting is allowed.
    assign self_nest   = act_found && (cand_idx == act_idx);
    assign may_preempt = cand_found &&
                         (!act_found || (cand_idx < act_idx) || (self_nest && nest_en_i));
    assign take_now    = (state_q == ST_READY) && !ret_i && may_preempt;

    always_comb begin
        take_mask = '0;
        if (take_now) begin
            take_mask[cand_idx] = 1'b1;
        end
    end

    always_comb begin
        retire_mask = '0;
        if (ret_i && act_found && !ret_tag_i) begin
            retire_mask[act_idx] = 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (ret_i)         state_d = ST_LEAVE;
                else if (take_now) state_d = ST_ENTER;
            end
            ST_ENTER: begin
                if (ret_i) state_d = ST_LEAVE;
                else       state_d = ST_READY;
            end
            ST_LEAVE: begin
                if (ret_i) state_d = ST_LEAVE;
                else       state_d = ST_READY;
            end
            default: state_d = ST_READY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Level bookkeeping: latch, entry and retirement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            inserv_q <= '0;
        end else begin
            pend_q   <= (pend_q & ~take_mask) | raise_i;
            inserv_q <= (inserv_q & ~retire_mask) | take_mask;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_o        <= 1'b0;
            take_level_o  <= '0;
            take_vector_o <= '0;
            saved_ret_o   <= '0;
        end else begin
            take_o <= take_now;
            if (take_now) begin
                take_level_o  <= cand_idx;
                take_vector_o <= vec_rd;
                saved_ret_o   <= (cur_pc_i & ~AW'(1)) | AW'(self_nest);
            end
        end
    end

    assign pend_o   = pend_q;
    assign inserv_o = inserv_q;

endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
    parameter int NLVL = 16,
    parameter int LW   = $clog2(NLVL)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NLVL-1:0] enable_i,
    input logic            ret_i,
    input logic            ret_tag_i,
    input logic [NLVL-1:0] inserv_o,
    input logic            take_o,
    input logic [LW-1:0]   take_level_o
);

    logic [NLVL-1:0] en_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= enable_i;
    end

    // R4
    take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R4
    take_inserv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> inserv_o[take_level_o]);

    // R2
    take_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> en_q[take_level_o]);

    // R9
    ret_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i |=> !take_o ##1 !take_o);

    // R8
    ret_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && ret_tag_i) |=> $stable(inserv_o));

    // R8
    ret_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !ret_tag_i && (inserv_o != '0)) |=>
            ($countones(inserv_o) + 1 == $countones($past(inserv_o))));

endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.NLVL(NLVL), .LW(LW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .ret_i        (ret_i),
    .ret_tag_i    (ret_tag_i),
    .inserv_o     (inserv_o),
    .take_o       (take_o),
    .take_level_o (take_level_o)
);

// File: tb/tb_irq_nest_ctrl.sv
`timescale 1ns/1ps
module tb_irq_nest_ctrl;

    localparam int NLVL = 16;
    localparam int AW   = 32;
    localparam int LW   = 4;
    localparam logic [AW-1:0] PC = 32'h0000_2468;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NLVL-1:0] raise_i = '0;
    logic [NLVL-1:0] enable_i = '0;
    logic            nest_en_i = 1'b0;
    logic            vec_we_i = 1'b0;
    logic [LW-1:0]   vec_sel_i = '0;
    logic [AW-1:0]   vec_data_i = '0;
    logic [AW-1:0]   cur_pc_i = PC;
    logic            ret_i = 1'b0;
    logic            ret_tag_i = 1'b0;
    logic [NLVL-1:0] pend_o;
    logic [NLVL-1:0] inserv_o;
    logic            take_o;
    logic [LW-1:0]   take_level_o;
    logic [AW-1:0]   take_vector_o;
    logic [AW-1:0]   saved_ret_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    irq_nest_ctrl #(.NLVL(NLVL), .AW(AW), .LW(LW)) dut (.*);

    // {raise, enable, expect_take, expect_level}
    localparam int NROW = 6;
    localparam logic [36:0] TBL [NROW] = '{
        {16'h0800, 16'hFFFF, 1'b1, 4'd11},  // R3 single
        {16'h2800, 16'hFFFF, 1'b1, 4'd11},  // R3 11 before 13
        {16'h7000, 16'hEFFF, 1'b1, 4'd13},  // R3 skip disabled 12
        {16'h1000, 16'hEFFF, 1'b0, 4'd0},   // R2 disabled only
        {16'h4008, 16'hFFFF, 1'b1, 4'd3},   // R3 level 3 wins
        {16'h0000, 16'hFFFF, 1'b0, 4'd0}    // nothing raised
    };

    function automatic logic [AW-1:0] vec_of(int l);
        return 32'h0000_1000 + AW'(l * 64);
    endfunction

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        raise_i = '0;
        ret_i = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        for (int l = 0; l < NLVL; l++) begin
            vec_we_i = 1'b1;
            vec_sel_i = LW'(l);
            vec_data_i = vec_of(l);
            tick(1);
        end
        vec_we_i = 1'b0;
    endtask

    task automatic pulse(logic [NLVL-1:0] m);
        raise_i = m;
        tick(1);
        raise_i = '0;
    endtask

    task automatic do_ret(logic tag);
        ret_i = 1'b1;
        ret_tag_i = tag;
        tick(1);
        ret_i = 1'b0;
        ret_tag_i = 1'b0;
    endtask

    initial begin
        tick(1);
        check("R1 pend", AW'(pend_o), '0);
        check("R1 inserv", AW'(inserv_o), '0);
        check("R1 take", AW'(take_o), '0);

        // Table walk
        for (int r = 0; r < NROW; r++) begin
            do_reset();
            enable_i = TBL[r][20:5];
            nest_en_i = 1'b0;
            pulse(TBL[r][36:21]);
            tick(1);
            check("R3 take flag", AW'(take_o), AW'(TBL[r][4]));
            if (TBL[r][4]) begin
                check("R4 level", AW'(take_level_o), AW'(TBL[r][3:0]));
                check("R10 vector", take_vector_o, vec_of(int'(TBL[r][3:0])));
            end else begin
                check("R2 pend kept", AW'(pend_o), AW'(TBL[r][36:21]));
            end
        end

        // Self-nesting disabled scenario
        do_reset();
        enable_i = 16'h6800;
        nest_en_i = 1'b0;
        pulse(16'h7800);
        tick(1);
        check("R3 first", AW'(take_level_o), 32'd11);
        check("R4 take", AW'(take_o), 32'd1);
        check("R4 inserv", AW'(inserv_o), 32'h0800);
        check("R4 pend", AW'(pend_o), 32'h7000);
        check("R6 saved", saved_ret_o, PC);
        tick(1);
        check("R4 one cycle", AW'(take_o), 32'd0);
        pulse(16'h0800);
        check("R6 only pend", AW'(pend_o[11]), 32'd1);
        tick(2);
        check("R6 no reentry", AW'(take_o), 32'd0);
        do_ret(1'b0);
        tick(2);
        check("R6 after return", AW'(take_o), 32'd1);
        check("R6 level", AW'(take_level_o), 32'd11);
        check("R6 bit0 clear", saved_ret_o, PC);
        tick(1);
        do_ret(1'b0);
        tick(2);
        check("R3 then 13", AW'(take_level_o), 32'd13);
        check("R3 take 13", AW'(take_o), 32'd1);
        check("R2 12 stays", AW'(pend_o), 32'h5000);
        check("R10 vector 13", take_vector_o, vec_of(13));
        tick(1);
        do_ret(1'b1);
        check("R8 keep", AW'(inserv_o), 32'h2000);
        tick(2);
        check("R5 14 blocked", AW'(take_o), 32'd0);
        enable_i = 16'h7800;
        tick(1);
        check("R5 12 preempts", AW'(take_level_o), 32'd12);
        check("R5 inserv", AW'(inserv_o), 32'h3000);
        tick(1);
        do_ret(1'b0);
        check("R8 clear lowest", AW'(inserv_o), 32'h2000);
        tick(2);
        check("R5 still blocked", AW'(take_o), 32'd0);

        // Self-nesting enabled scenario
        do_reset();
        enable_i = 16'hFFFF;
        nest_en_i = 1'b1;
        cur_pc_i = 32'h0000_ABCD;
        pulse(16'h0800);
        tick(1);
        check("R10 pc bit0 replaced", saved_ret_o, 32'h0000_ABCC);
        tick(1);
        pulse(16'h0800);
        tick(1);
        check("R7 take", AW'(take_o), 32'd1);
        check("R7 saved bit0", saved_ret_o, 32'h0000_ABCD);
        check("R7 inserv", AW'(inserv_o), 32'h0800);
        tick(1);
        pulse(16'h4000);
        tick(2);
        check("R5 lower blocked", AW'(take_o), 32'd0);
        ret_i = 1'b1;
        ret_tag_i = 1'b0;
        raise_i = 16'h0800;
        tick(1);
        ret_i = 1'b0;
        raise_i = '0;
        check("R9 no take e1", AW'(take_o), 32'd0);
        check("R9 inserv", AW'(inserv_o), 32'h0000);
        check("R9 pend", AW'(pend_o), 32'h4800);
        tick(1);
        check("R9 no take e2", AW'(take_o), 32'd0);
        tick(1);
        check("R9 take e3", AW'(take_o), 32'd1);
        check("R9 level", AW'(take_level_o), 32'd11);

        // Vector rewrite
        vec_we_i = 1'b1;
        vec_sel_i = 4'd14;
        vec_data_i = 32'hCAFE_0000;
        tick(1);
        vec_we_i = 1'b0;
        do_ret(1'b0);
        tick(2);
        check("R10 rewritten", take_vector_o, 32'hCAFE_0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule